// File: doc/BRIEF.md
# Half-Bridge Complementary Gate Pulse Generator

This block drives the two switches of a half-bridge from a digital switching-period word and a dead-time code. Each switching period splits into two equal halves. The low-side half comes first and the high-side half follows. Each half opens with a dead interval in which both gates are low, and the gate owning that half is high for the rest of it. A dead interval therefore precedes every turn-on, and the two gates are never high together.

Light-load pulse skipping is controlled by two flags from an external comparator pair on the control voltage. A "below lower threshold" flag (0.4 V) stops switching. An "above upper threshold" flag (0.6 V) lets it resume. Between the two thresholds the previous decision is kept. The period word is clamped to the shortest allowed period, which is the frequency cap. The dead-time code is decoded to a cycle count with two fixed fallbacks, one for a shorted programming input and one for an open one. Period and dead time are captured together once per period, at the start of the low-side half, and held until the next period starts.

With the default parameters and a 100 MHz clock, one cycle is 10 ns, the shortest period is 168 cycles (just under 600 kHz), and the dead-time range is 10 to 60 cycles (100 to 600 ns).

Top module: `hb_gate_pulser`

States and transitions (all in the top module):

- IDLE holds both gates low. It moves to LO_DEAD when the skip enable is set, and period and dead time are loaded at that point.
- LO_DEAD moves to LO_ON after D cycles.
- LO_ON moves to HI_DEAD after H-D cycles.
- HI_DEAD moves to HI_ON after D cycles.
- HI_ON moves to LO_DEAD after H-D cycles, and the period and dead time are loaded again.
- Any state other than IDLE moves to IDLE when the skip enable is clear.

## Requirements
- R1: While reset is asserted, and after reset until the skip enable has been set, both gate outputs are 0.
- R2: The two outputs are never 1 in the same cycle. Each period is 2*H cycles. For the first D cycles both outputs are 0, then gate_lo is 1 for H-D cycles. For the next D cycles both outputs are 0, then gate_hi is 1 for H-D cycles.
- R3: The effective period is max(period_word, MIN_PER), where MIN_PER defaults to 168. The half period H is that value divided by 2 and rounded down, so an odd word loses one cycle.
- R4: dead_code is decoded to a cycle count D as follows. Code 0 (shorted input) gives 5 cycles. The all-ones code 255 (open input) gives 100 cycles. Any other code gives its own value clamped to the range 10 to 60.
- R5: If the decoded dead time is at least H, D becomes H-1, so each gate is high for at least one cycle.
- R6: Period and dead time are sampled only when LO_DEAD is entered. A change of the inputs during a period has no effect until the next period.
- R7: The skip enable is held in a register that updates on each clock edge. If ctl_below_lo is 1 at an edge, the enable is cleared at that edge. At the next edge the state machine goes to IDLE, so both outputs are 0 from then on.
- R8: With both flags at 0 the enable keeps its value. An edge with ctl_above_hi=1 (and ctl_below_lo=0) sets the enable. The following edge enters LO_DEAD, so switching always resumes on the low side after one full dead interval.
- R9: If both flags are 1 at the same edge, the disable takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_word | input | PER_W (16) | Requested switching period in clock cycles |
| dead_code | input | CODE_W (8) | Dead-time code: 0 = shorted input, 255 = open input, otherwise a cycle count |
| ctl_above_hi | input | 1 | Control voltage is above the upper threshold (resume) |
| ctl_below_lo | input | 1 | Control voltage is below the lower threshold (skip) |
| gate_lo | output | 1 | Low-side gate command |
| gate_hi | output | 1 | High-side gate command |

## Verification
A behavioural model of the period position is compared with both gates every cycle. The run covers two shapes of period word: one below the frequency cap, and an odd word that has to round down. A design that fails to clamp would switch too fast, and one that mishandles the rounding would drift by a cycle in each period. Both fallback dead-time codes and both clamp edges are exercised. The open code is also combined with the shortest period, where a design without the fit rule would never turn a gate on or would overlap the two gates. The dead-time code is changed in the middle of a period, which catches a design that applies the change immediately. The skip flags are walked through enable, hold, disable and the case where both are set, which catches a missing hysteresis, the wrong priority, or a resume that starts on the high side.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LO_DEAD = 3'd1,
        ST_LO_ON   = 3'd2,
        ST_HI_DEAD = 3'd3,
        ST_HI_ON   = 3'd4
    } hb_state_e;

endpackage

// File: rtl/hbg_dead_decode.sv
module hbg_dead_decode #(
    parameter int CODE_W    = 8,
    parameter int OUT_W     = 16,
    parameter int SHORT_CYC = 5,
    parameter int OPEN_CYC  = 100,
    parameter int MIN_CYC   = 10,
    parameter int MAX_CYC   = 60
) (
    input  logic [CODE_W-1:0] code,
    output logic [OUT_W-1:0]  cycles
);
    localparam logic [OUT_W-1:0] L_SHORT = OUT_W'(SHORT_CYC);
    localparam logic [OUT_W-1:0] L_OPEN  = OUT_W'(OPEN_CYC);
    localparam logic [OUT_W-1:0] L_MIN   = OUT_W'(MIN_CYC);
    localparam logic [OUT_W-1:0] L_MAX   = OUT_W'(MAX_CYC);

    logic [OUT_W-1:0] raw;

    always_comb begin
        raw = OUT_W'(code);
        if (code == '0)         cycles = L_SHORT;
        else if (code == '1)    cycles = L_OPEN;
        else if (raw < L_MIN)   cycles = L_MIN;
        else if (raw > L_MAX)   cycles = L_MAX;
        else                    cycles = raw;
    end

    // R4: decoded count always within the span of the four constants
    always_comb begin
        a_r4_decode_range: assert (cycles != '0);
    end
endmodule

// File: rtl/hbg_period_clamp.sv
module hbg_period_clamp #(
    parameter int PER_W   = 16,
    parameter int MIN_PER = 168
) (
    input  logic [PER_W-1:0] period,
    output logic [PER_W-1:0] half
);
    localparam logic [PER_W-1:0] L_MIN_PER = PER_W'(MIN_PER);

    logic [PER_W-1:0] eff;

    always_comb begin
        eff  = (period < L_MIN_PER) ? L_MIN_PER : period;
        half = eff >> 1;
    end
endmodule

// File: rtl/hbg_skip_gate.sv
module hbg_skip_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi,
    input  logic below_lo,
    output logic run_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_en <= 1'b0;
        else if (below_lo) run_en <= 1'b0;
        else if (above_hi) run_en <= 1'b1;
    end

    a_r9_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        below_lo |=> !run_en);

    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!below_lo && !above_hi) |=> $stable(run_en));
endmodule

// File: rtl/hb_gate_pulser.sv
module hb_gate_pulser #(
    parameter int PER_W     = 16,
    parameter int CODE_W    = 8,
    parameter int MIN_PER   = 168,
    parameter int SHORT_CYC = 5,
    parameter int OPEN_CYC  = 100,
    parameter int MIN_CYC   = 10,
    parameter int MAX_CYC   = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period_word,
    input  logic [CODE_W-1:0] dead_code,
    input  logic              ctl_above_hi,
    input  logic              ctl_below_lo,
    output logic              gate_lo,
    output logic              gate_hi
);
    import hbg_pkg::*;

    localparam logic [PER_W-1:0] L_ONE      = PER_W'(1);
    localparam logic [PER_W-1:0] L_HALF_MIN = PER_W'(MIN_PER / 2);

    hb_state_e        state, state_d;
    logic [PER_W-1:0] cnt, cnt_d;
    logic [PER_W-1:0] half_q, dead_q, on_len;
    logic [PER_W-1:0] half_in, dead_in, dead_fit;
    logic             run_en, load;

    hbg_period_clamp #(.PER_W(PER_W), .MIN_PER(MIN_PER)) u_clamp (
        .period (period_word),
        .half   (half_in)
    );

    hbg_dead_decode #(
        .CODE_W(CODE_W), .OUT_W(PER_W), .SHORT_CYC(SHORT_CYC),
        .OPEN_CYC(OPEN_CYC), .MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)
    ) u_dead (
        .code   (dead_code),
        .cycles (dead_in)
    );

    hbg_skip_gate u_skip (
        .clk      (clk),
        .rst_n    (rst_n),
        .above_hi (ctl_above_hi),
        .below_lo (ctl_below_lo),
        .run_en   (run_en)
    );

    // dead time must leave at least one on-cycle in each half
    always_comb begin
        dead_fit = (dead_in >= half_in) ? (half_in - L_ONE) : dead_in;
        on_len   = half_q - dead_q;
    end

    // next-state logic
    always_comb begin
        state_d = state;
        cnt_d   = cnt + L_ONE;
        load    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_d = '0;
                if (run_en) begin
                    state_d = ST_LO_DEAD;
                    load    = 1'b1;
                end
            end
            ST_LO_DEAD: if (cnt == dead_q - L_ONE) begin
                state_d = ST_LO_ON;
                cnt_d   = '0;
            end
            ST_LO_ON: if (cnt == on_len - L_ONE) begin
                state_d = ST_HI_DEAD;
                cnt_d   = '0;
            end
            ST_HI_DEAD: if (cnt == dead_q - L_ONE) begin
                state_d = ST_HI_ON;
                cnt_d   = '0;
            end
            ST_HI_ON: if (cnt == on_len - L_ONE) begin
                state_d = ST_LO_DEAD;
                cnt_d   = '0;
                load    = 1'b1;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
        if (state != ST_IDLE && !run_en) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            load    = 1'b0;
        end
    end

    // state register and per-period sample-and-hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            half_q <= L_HALF_MIN;
            dead_q <= L_ONE;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            if (load) begin
                half_q <= half_in;
                dead_q <= dead_fit;
            end
        end
    end

    // outputs
    always_comb begin
        gate_lo = (state == ST_LO_ON);
        gate_hi = (state == ST_HI_ON);
    end

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_lo && gate_hi));

    a_r7_stop_next: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && state != ST_IDLE) |=> (state == ST_IDLE));

    a_r8_resume_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && run_en) |=> (state == ST_LO_DEAD));

    a_r6_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LO_DEAD || state == ST_LO_ON || state == ST_HI_DEAD)
        |=> ($stable(dead_q) && $stable(half_q)));

    a_r5_dead_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (dead_q < half_q && dead_q != '0));

    a_r3_half_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (half_q >= L_HALF_MIN));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!gate_lo && !gate_hi));
endmodule

// File: tb/hb_gate_pulser_tb.sv
module hb_gate_pulser_tb;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] period_word = 16'd1000;
    logic [7:0]  dead_code = 8'd20;
    logic        ctl_above_hi = 1'b0;
    logic        ctl_below_lo = 1'b0;
    logic        gate_lo, gate_hi;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    hb_gate_pulser u_dut (
        .clk(clk), .rst_n(rst_n), .period_word(period_word), .dead_code(dead_code),
        .ctl_above_hi(ctl_above_hi), .ctl_below_lo(ctl_below_lo),
        .gate_lo(gate_lo), .gate_hi(gate_hi)
    );

    always #(CLK_NS / 2) clk = ~clk;

    // behavioural reference: position within the period
    int m_en = 0, m_run = 0, m_pos = 0, m_H = 84, m_D = 1;

    function automatic void m_load();
        int eff, d;
        eff = (int'(period_word) < 168) ? 168 : int'(period_word);
        m_H = eff / 2;
        if (dead_code == 8'd0)        d = 5;
        else if (dead_code == 8'd255) d = 100;
        else if (dead_code < 8'd10)   d = 10;
        else if (dead_code > 8'd60)   d = 60;
        else                          d = int'(dead_code);
        if (d >= m_H) d = m_H - 1;
        m_D = d;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_run = 0; m_pos = 0;
        end else begin
            if (m_run == 0) begin
                if (m_en != 0) begin m_run = 1; m_pos = 0; m_load(); end
            end else if (m_en == 0) begin
                m_run = 0;
            end else begin
                m_pos++;
                if (m_pos == 2 * m_H) begin m_pos = 0; m_load(); end
            end
            if (ctl_below_lo)      m_en = 0;
            else if (ctl_above_hi) m_en = 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    bit prev_lo = 0;
    bit armed = 0;
    int gap = 0;

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            int exp_lo, exp_hi;
            @(negedge clk);
            exp_lo = (m_run != 0 && m_pos >= m_D && m_pos < m_H) ? 1 : 0;
            exp_hi = (m_run != 0 && m_pos >= m_H + m_D) ? 1 : 0;
            check(int'(gate_lo) == exp_lo, {cur_req, " gate_lo"}, int'(gate_lo), exp_lo);
            check(int'(gate_hi) == exp_hi, {cur_req, " gate_hi"}, int'(gate_hi), exp_hi);
            check(!(gate_lo && gate_hi), "R2 overlap", 1, 0);
            // measured dead interval low-side fall -> high-side rise
            if (m_run == 0) armed = 0;
            if (prev_lo && !gate_lo && !gate_hi) begin armed = 1; gap = 1; end
            else if (armed && !gate_lo && !gate_hi) gap++;
            else if (armed && gate_hi) begin
                check(gap == m_D, "R2 dead measured", gap, m_D);
                armed = 0;
            end
            prev_lo = gate_lo;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset and quiet until enabled
        cur_req = "R1";
        step(5);
        rst_n = 1'b1;
        step(30);

        // R8: single pulse on upper flag enables; hold while between thresholds
        cur_req = "R8";
        ctl_above_hi = 1'b1;
        step(1);
        ctl_above_hi = 1'b0;
        step(2500);

        // R4: shorted, open, low clamp, high clamp
        cur_req = "R4";
        dead_code = 8'd0;   step(2200);
        dead_code = 8'd255; step(2200);
        dead_code = 8'd3;   step(2200);
        dead_code = 8'd200; step(2200);

        // R3: below cap and odd word
        cur_req = "R3";
        dead_code = 8'd20;
        period_word = 16'd50;   step(800);
        period_word = 16'd1001; step(3000);

        // R5: open code with shortest period
        cur_req = "R5";
        period_word = 16'd100; dead_code = 8'd255;
        step(900);

        // R6: mid-period change of code and period
        cur_req = "R6";
        period_word = 16'd1000; dead_code = 8'd30;
        step(1600);
        dead_code = 8'd55; period_word = 16'd400;
        step(300);
        dead_code = 8'd12;
        step(2500);

        // R7: lower flag stops switching
        cur_req = "R7";
        ctl_below_lo = 1'b1;
        step(1);
        ctl_below_lo = 1'b0;
        step(300);
        check(!gate_lo && !gate_hi, "R7 stopped", int'(gate_lo | gate_hi), 0);

        // R8: resume on low side after dead interval
        cur_req = "R8";
        ctl_above_hi = 1'b1;
        step(1);
        ctl_above_hi = 1'b0;
        step(1500);

        // R9: both flags together disable
        cur_req = "R9";
        ctl_above_hi = 1'b1; ctl_below_lo = 1'b1;
        step(3);
        ctl_above_hi = 1'b0; ctl_below_lo = 1'b0;
        step(500);
        check(!gate_lo && !gate_hi, "R9 both flags", int'(gate_lo | gate_hi), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule